// File: doc/BRIEF.md
# Polygon Edge Marking Post-Pass

This block runs once every opaque polygon of a frame has been rasterized. Each pixel arrives in raster order carrying a possible-edge flag, a 6-bit polygon ID, a 24-bit depth and a 15-bit colour. The rasterizer only flags edge pixels and leaves their normal colour in place. This block looks at the four orthogonal neighbours of every flagged pixel. It replaces the colour with an edge colour when a neighbour belongs to another polygon and lies strictly farther away.

Three scanlines are held in a ring store: the previous, current and next lines. The output of a pixel is issued once its lower neighbour has arrived, or once the whole frame has arrived. A neighbour position off the screen is replaced by a configured rear-plane polygon ID and by the depth derived from the 15-bit clear-depth setting. The edge colour comes from an 8-entry table selected by the top three bits of the pixel's polygon ID. Input and output use valid/ready handshakes. The output stream carries frame-start and line-end markers.

Top module: `edge_mark_top`

## Requirements
- R1: A pixel whose edge flag is 0 leaves with its input colour unchanged, whatever its neighbours hold.
- R2: A flagged pixel leaves with edge colour `edge_palette[15*k +: 15]`, where k = polygon ID bits 5:3, when at least one of its up, down, left and right neighbours has a different polygon ID and a depth strictly greater than the pixel's own depth.
- R3: A neighbour with a different polygon ID whose depth is equal to or smaller than the flagged pixel's depth does not cause recolouring.
- R4: Neighbours that share the flagged pixel's polygon ID never cause recolouring, whatever their depth.
- R5: A neighbour position outside the screen (row above row 0, row below the last row, column left of column 0, column right of the last column) takes the polygon ID `rear_id`.
- R6: An off-screen neighbour takes the depth `clear_val * 0x200 + 0x1FF`. A flagged border pixel whose depth is one below that value gets the edge colour. A flagged border pixel whose depth equals that value does not.
- R7: Every accepted pixel leaves exactly once, in raster order. `out_sof` is 1 only on the first pixel of each frame. `out_eol` is 1 only on the pixel in column SCR_W-1.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output pixel and its markers hold unchanged on the next cycle.
- R9: Input stalls and output back-pressure lose or duplicate no pixel. The number of pixels accepted but not yet delivered never exceeds 2*SCR_W+1. Back-to-back frames are processed without a reset between them.
- R10: In the cycle after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_flag | input | 1 | Possible-edge flag set during rasterization |
| in_id | input | 6 | Polygon ID of the pixel |
| in_depth | input | 24 | Buffer depth of the pixel |
| in_color | input | 15 | Rendered colour of the pixel |
| rear_id | input | 6 | Polygon ID used for off-screen neighbours |
| clear_val | input | 15 | Clear-depth setting, converted for off-screen neighbours |
| edge_palette | input | 120 | Eight 15-bit edge colours, entry k at bits 15k+14:15k |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_color | output | 15 | Final colour of the pixel |
| out_sof | output | 1 | First pixel of a frame |
| out_eol | output | 1 | Last pixel of a scanline |

## Verification
The bench builds an interior pair of pixels with an ID that differs from its surroundings. With that pair in front, only the pair takes the edge colour. With the pair equally deep or behind, the surrounding pixels take it on the sides where the pair is farther. A design that tested less-or-equal, or that ignored the ID comparison, would recolour the wrong set of pixels. Border pixels are placed one below and exactly at the converted clear depth with a differing rear ID. A wrong conversion, a missing substitution, or a comparison against the stale data of the neighbouring line in the ring would show up as a mismatch on the border. Stalls on both sides and two back-to-back frames expose any ring overwrite, lost pixel or misplaced marker.

// File: rtl/edge_mark_pkg.sv
package edge_mark_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ID_W      = 6;
    localparam int DEPTH_W   = 24;
    localparam int COLOR_W   = 15;
    localparam int CLEAR_W   = 15;
    localparam int PAL_SEL_W = 3;
    localparam int PAL_N     = 1 << PAL_SEL_W;
    localparam int PAL_W     = PAL_N * COLOR_W;
    localparam int CLEAR_SH  = DEPTH_W - CLEAR_W;
    localparam int N_NBR     = 4;

    // one stored pixel
    typedef struct packed {
        logic               flag;
        logic [ID_W-1:0]    id;
        logic [DEPTH_W-1:0] depth;
        logic [COLOR_W-1:0] color;
    } epx_t;

    // what a neighbour contributes to the decision
    typedef struct packed {
        logic [ID_W-1:0]    id;
        logic [DEPTH_W-1:0] depth;
    } nb_t;

    // clear setting scaled by 2^CLEAR_SH with all low bits filled
    function automatic logic [DEPTH_W-1:0] clear_to_depth(input logic [CLEAR_W-1:0] v);
        return {v, {CLEAR_SH{1'b1}}};
    endfunction
endpackage

// File: rtl/edge_flow_ctrl.sv
module edge_flow_ctrl #(
    parameter int SCR_W = 256,
    parameter int SCR_H = 192
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_fire,
    input  logic                             slot_free,
    output logic                             in_ready,
    output logic                             issue,
    output logic [$clog2(3*SCR_W)-1:0]       wr_addr,
    output logic [$clog2(3*SCR_W)-1:0]       rd_addr,
    output logic [$clog2(SCR_W)-1:0]         col,
    output logic [$clog2(SCR_H)-1:0]         row
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TOTAL = SCR_W * SCR_H;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam int RING  = 3 * SCR_W;
    localparam int AW    = $clog2(RING);
    localparam int XW    = $clog2(SCR_W);
    localparam int YW    = $clog2(SCR_H);

    localparam logic [CW-1:0] TOTAL_C = CW'(TOTAL);
    localparam logic [CW-1:0] LAST_C  = CW'(TOTAL - 1);
    localparam logic [CW-1:0] LAG_C   = CW'(SCR_W + 1);
    localparam logic [CW-1:0] WIN_C   = CW'(2 * SCR_W);
    localparam logic [AW-1:0] RLAST_C = AW'(RING - 1);
    localparam logic [XW-1:0] XLAST_C = XW'(SCR_W - 1);

    logic [CW-1:0] in_cnt;
    logic [CW-1:0] out_cnt;
    logic [CW-1:0] gap;
    logic          all_in;
    logic          avail;
    logic          frame_end;

    assign gap       = in_cnt - out_cnt;
    assign all_in    = (in_cnt == TOTAL_C);
    // keep the line above the issue point alive in the ring
    assign in_ready  = !all_in && (gap < WIN_C);
    // issue once the pixel below has arrived, or the frame is complete
    assign avail     = all_in || (gap >= LAG_C);
    assign issue     = avail && slot_free;
    assign frame_end = issue && (out_cnt == LAST_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt  <= '0;
            out_cnt <= '0;
            wr_addr <= '0;
            rd_addr <= '0;
            col     <= '0;
            row     <= '0;
        end else begin
            if (in_fire) begin
                in_cnt  <= in_cnt + 1'b1;
                wr_addr <= (wr_addr == RLAST_C) ? '0 : wr_addr + 1'b1;
            end
            if (issue) begin
                out_cnt <= out_cnt + 1'b1;
                rd_addr <= (rd_addr == RLAST_C) ? '0 : rd_addr + 1'b1;
                if (col == XLAST_C) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end
            if (frame_end) begin
                in_cnt  <= '0;
                out_cnt <= '0;
                wr_addr <= '0;
                rd_addr <= '0;
                col     <= '0;
                row     <= '0;
            end
        end
    end
endmodule

// File: rtl/edge_line_ring.sv
module edge_line_ring
    import edge_mark_pkg::*;
#(
    parameter int SCR_W = 256
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [$clog2(3*SCR_W)-1:0]   wr_addr,
    input  epx_t                         wr_px,
    input  logic [$clog2(3*SCR_W)-1:0]   ctr_addr,
    output epx_t                         ctr_px,
    output epx_t                         up_px,
    output epx_t                         dn_px,
    output epx_t                         lf_px,
    output epx_t                         rt_px
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int RING = 3 * SCR_W;
    localparam int AW   = $clog2(RING);

    localparam logic [AW:0] W_X     = (AW+1)'(SCR_W);
    localparam logic [AW:0] W2_X    = (AW+1)'(2 * SCR_W);
    localparam logic [AW:0] RING_X  = (AW+1)'(RING);
    localparam logic [AW-1:0] RLAST = AW'(RING - 1);

    epx_t mem [RING];

    logic [AW:0]   c_x;
    logic [AW:0]   up_x;
    logic [AW:0]   dn_x;
    logic [AW-1:0] up_a;
    logic [AW-1:0] dn_a;
    logic [AW-1:0] lf_a;
    logic [AW-1:0] rt_a;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_addr] <= wr_px;
        end
    end

    always_comb begin
        c_x  = {1'b0, ctr_addr};
        up_x = (c_x >= W_X) ? (c_x - W_X) : (c_x + W2_X);
        dn_x = ((c_x + W_X) < RING_X) ? (c_x + W_X) : (c_x - W2_X);
        up_a = up_x[AW-1:0];
        dn_a = dn_x[AW-1:0];
        lf_a = (ctr_addr == '0) ? RLAST : ctr_addr - 1'b1;
        rt_a = (ctr_addr == RLAST) ? '0 : ctr_addr + 1'b1;
    end

    assign ctr_px = mem[ctr_addr];
    assign up_px  = mem[up_a];
    assign dn_px  = mem[dn_a];
    assign lf_px  = mem[lf_a];
    assign rt_px  = mem[rt_a];
endmodule

// File: rtl/edge_judge.sv
module edge_judge
    import edge_mark_pkg::*;
(
    input  epx_t                  ctr,
    input  nb_t  [N_NBR-1:0]      nbrs,
    input  logic [N_NBR-1:0]      off_scr,
    input  logic [ID_W-1:0]       rear_id,
    input  logic [CLEAR_W-1:0]    clear_val,
    input  logic [PAL_W-1:0]      palette,
    output logic [COLOR_W-1:0]    color
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [DEPTH_W-1:0]   rear_depth;
    logic [N_NBR-1:0]     hit;
    logic [PAL_SEL_W-1:0] sel;
    logic [COLOR_W-1:0]   edge_col;

    assign rear_depth = clear_to_depth(clear_val);

    for (genvar k = 0; k < N_NBR; k++) begin : g_nbr
        logic [ID_W-1:0]    n_id;
        logic [DEPTH_W-1:0] n_depth;
        assign n_id    = off_scr[k] ? rear_id    : nbrs[k].id;
        assign n_depth = off_scr[k] ? rear_depth : nbrs[k].depth;
        assign hit[k]  = (n_id != ctr.id) && (ctr.depth < n_depth);
    end

    assign sel      = ctr.id[ID_W-1 -: PAL_SEL_W];
    assign edge_col = palette[sel*COLOR_W +: COLOR_W];
    assign color    = (ctr.flag && (|hit)) ? edge_col : ctr.color;
endmodule

// File: rtl/edge_mark_top.sv
module edge_mark_top
    import edge_mark_pkg::*;
#(
    parameter int SCR_W = 256,
    parameter int SCR_H = 192
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_flag,
    input  logic [5:0]         in_id,
    input  logic [23:0]        in_depth,
    input  logic [14:0]        in_color,
    input  logic [5:0]         rear_id,
    input  logic [14:0]        clear_val,
    input  logic [119:0]       edge_palette,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [14:0]        out_color,
    output logic               out_sof,
    output logic               out_eol
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = $clog2(3 * SCR_W);
    localparam int XW = $clog2(SCR_W);
    localparam int YW = $clog2(SCR_H);
    localparam logic [XW-1:0] XLAST = XW'(SCR_W - 1);
    localparam logic [YW-1:0] YLAST = YW'(SCR_H - 1);

    logic          in_fire;
    logic          slot_free;
    logic          issue;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [XW-1:0] col;
    logic [YW-1:0] row;

    epx_t wr_px;
    epx_t ctr_px;
    epx_t up_px;
    epx_t dn_px;
    epx_t lf_px;
    epx_t rt_px;

    nb_t  [N_NBR-1:0] nbrs;
    logic [N_NBR-1:0] off_scr;
    logic [COLOR_W-1:0] judged;

    assign in_fire   = in_valid && in_ready;
    assign slot_free = !out_valid || out_ready;

    always_comb begin
        wr_px.flag  = in_flag;
        wr_px.id    = in_id;
        wr_px.depth = in_depth;
        wr_px.color = in_color;
    end

    edge_flow_ctrl #(.SCR_W(SCR_W), .SCR_H(SCR_H)) flow_i (
        .clk       (clk),
        .rst       (rst),
        .in_fire   (in_fire),
        .slot_free (slot_free),
        .in_ready  (in_ready),
        .issue     (issue),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .col       (col),
        .row       (row)
    );

    edge_line_ring #(.SCR_W(SCR_W)) ring_i (
        .clk      (clk),
        .we       (in_fire),
        .wr_addr  (wr_addr),
        .wr_px    (wr_px),
        .ctr_addr (rd_addr),
        .ctr_px   (ctr_px),
        .up_px    (up_px),
        .dn_px    (dn_px),
        .lf_px    (lf_px),
        .rt_px    (rt_px)
    );

    // neighbour order: up, down, left, right
    always_comb begin
        nbrs[0].id = up_px.id;  nbrs[0].depth = up_px.depth;
        nbrs[1].id = dn_px.id;  nbrs[1].depth = dn_px.depth;
        nbrs[2].id = lf_px.id;  nbrs[2].depth = lf_px.depth;
        nbrs[3].id = rt_px.id;  nbrs[3].depth = rt_px.depth;
        off_scr[0] = (row == '0);
        off_scr[1] = (row == YLAST);
        off_scr[2] = (col == '0);
        off_scr[3] = (col == XLAST);
    end

    edge_judge judge_i (
        .ctr       (ctr_px),
        .nbrs      (nbrs),
        .off_scr   (off_scr),
        .rear_id   (rear_id),
        .clear_val (clear_val),
        .palette   (edge_palette),
        .color     (judged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_color <= '0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
        end else if (issue) begin
            out_valid <= 1'b1;
            out_color <= judged;
            out_sof   <= (col == '0) && (row == '0);
            out_eol   <= (col == XLAST);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/edge_mark_checker.sv
module edge_mark_checker #(
    parameter int SCR_W = 256,
    parameter int SCR_H = 192
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [14:0] out_color,
    input logic        out_sof,
    input logic        out_eol
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [31:0] TOTAL_L = 32'(SCR_W * SCR_H);
    localparam logic [31:0] W_L     = 32'(SCR_W);
    localparam logic [31:0] WIN_L   = 32'(2 * SCR_W + 1);

    logic [31:0] n_in;
    logic [31:0] n_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_in  <= '0;
            n_out <= '0;
        end else begin
            if (in_valid && in_ready)   n_in  <= n_in + 1;
            if (out_valid && out_ready) n_out <= n_out + 1;
        end
    end

    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_color)
                                       && $stable(out_sof) && $stable(out_eol)));

    p_sof_place_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sof == ((n_out % TOTAL_L) == 32'd0)));

    p_eol_place_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_eol == ((n_out % W_L) == (W_L - 32'd1))));

    p_causal_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (n_out < n_in));

    p_window_r9: assert property (@(posedge clk) disable iff (rst)
        (n_in - n_out) <= WIN_L);
endmodule

bind edge_mark_top edge_mark_checker #(.SCR_W(SCR_W), .SCR_H(SCR_H)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_color (out_color),
    .out_sof   (out_sof),
    .out_eol   (out_eol)
);

// File: tb/edge_mark_top_tb_top.sv
module edge_mark_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W     = 4;
    localparam int H     = 3;
    localparam int TOTAL = W * H;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_flag = 1'b0;
    logic [5:0]   in_id = '0;
    logic [23:0]  in_depth = '0;
    logic [14:0]  in_color = '0;
    logic [5:0]   rear_id = '0;
    logic [14:0]  clear_val = '0;
    logic [119:0] edge_palette = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [14:0]  out_color;
    logic         out_sof;
    logic         out_eol;

    int n_checks = 0;
    int n_errors = 0;

    logic        f_flag  [TOTAL];
    logic [5:0]  f_id    [TOTAL];
    logic [23:0] f_depth [TOTAL];
    logic [14:0] f_color [TOTAL];

    always #2 clk = ~clk;

    edge_mark_top #(.SCR_W(W), .SCR_H(H)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_flag(in_flag), .in_id(in_id), .in_depth(in_depth), .in_color(in_color),
        .rear_id(rear_id), .clear_val(clear_val), .edge_palette(edge_palette),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_color(out_color), .out_sof(out_sof), .out_eol(out_eol)
    );

    function automatic logic [14:0] pal_entry(input int k);
        return 15'(32'h0100 + k * 32'h0111);
    endfunction

    function automatic logic [14:0] exp_color(input int idx);
        int x = idx % W;
        int y = idx / W;
        bit hit = 1'b0;
        for (int k = 0; k < 4; k++) begin
            int nx = x + ((k == 2) ? -1 : (k == 3) ? 1 : 0);
            int ny = y + ((k == 0) ? -1 : (k == 1) ? 1 : 0);
            logic [5:0]  nid;
            logic [23:0] nd;
            if (nx < 0 || nx >= W || ny < 0 || ny >= H) begin
                nid = rear_id;
                nd  = 24'(clear_val) * 24'h200 + 24'h1FF;
            end else begin
                nid = f_id[ny*W + nx];
                nd  = f_depth[ny*W + nx];
            end
            if (nid != f_id[idx] && f_depth[idx] < nd) hit = 1'b1;
        end
        if (f_flag[idx] && hit) return pal_entry(int'(f_id[idx] >> 3));
        return f_color[idx];
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // stream nfr frames of the current arrays, with optional stalls
    task automatic run_frames(input int nfr, input bit in_gaps, input bit out_bp, input string tag);
        int sent = 0;
        int got  = 0;
        int cyc  = 0;
        int tot  = nfr * TOTAL;
        while (got < tot && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            out_ready = out_bp ? ((cyc % 3) == 0) : 1'b1;
            if (out_valid && out_ready) begin
                int idx = got % TOTAL;
                logic [14:0] e = exp_color(idx);
                check(out_color == e, tag, $sformatf("pixel %0d colour", idx), 32'(out_color), 32'(e));
                check(out_sof == (idx == 0), "R7", $sformatf("pixel %0d sof", idx), 32'(out_sof), 32'(idx == 0));
                check(out_eol == ((idx % W) == W - 1), "R7", $sformatf("pixel %0d eol", idx),
                      32'(out_eol), 32'((idx % W) == W - 1));
                got++;
            end
            if (sent < tot && (!in_gaps || (cyc % 3) != 1)) begin
                int si = sent % TOTAL;
                in_valid = 1'b1;
                in_flag  = f_flag[si];
                in_id    = f_id[si];
                in_depth = f_depth[si];
                in_color = f_color[si];
                if (in_ready) sent++;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        check(got == tot, "R9", {tag, " delivered count"}, 32'(got), 32'(tot));
    endtask

    task automatic test_reset();
        check(out_valid == 1'b0, "R10", "out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", 32'(in_ready), 32'd1);
    endtask

    // R1: no flags, arbitrary IDs and depths
    task automatic test_passthrough();
        rear_id = 6'd0; clear_val = 15'h7FFF;
        for (int i = 0; i < TOTAL; i++) begin
            f_flag[i] = 1'b0; f_id[i] = 6'(i * 5); f_depth[i] = 24'(i * 24'h333);
            f_color[i] = 15'(32'h0A00 + i);
        end
        run_frames(1, 1'b0, 1'b0, "R1 passthrough");
    endtask

    // R2: interior pair in front of surroundings with another ID
    task automatic test_front_pair();
        rear_id = 6'o05; clear_val = 15'h7FFF;
        for (int i = 0; i < TOTAL; i++) begin
            f_flag[i] = 1'b1; f_id[i] = 6'o05; f_depth[i] = 24'h800; f_color[i] = 15'(32'h2000 + i);
        end
        f_id[5] = 6'o21; f_depth[5] = 24'h100;
        f_id[6] = 6'o21; f_depth[6] = 24'h100;
        run_frames(1, 1'b0, 1'b0, "R2 front pair");
        check(exp_color(5) == pal_entry(2), "R2", "model edge entry", 32'(exp_color(5)), 32'(pal_entry(2)));
    endtask

    // R3: pair equal and behind; the deeper one makes its neighbours edges
    task automatic set_depth_rule_frame();
        rear_id = 6'o05; clear_val = 15'h7FFF;
        for (int i = 0; i < TOTAL; i++) begin
            f_flag[i] = 1'b1; f_id[i] = 6'o05; f_depth[i] = 24'h800; f_color[i] = 15'(32'h3000 + i);
        end
        f_id[5] = 6'o21; f_depth[5] = 24'h800;
        f_id[6] = 6'o21; f_depth[6] = 24'h900;
    endtask

    task automatic test_depth_rule();
        set_depth_rule_frame();
        run_frames(1, 1'b0, 1'b0, "R3 equal/behind");
    endtask

    // R4/R5: one ID everywhere and rear ID equal, so nothing recolours
    task automatic test_same_id();
        rear_id = 6'o33; clear_val = 15'h0000;
        for (int i = 0; i < TOTAL; i++) begin
            f_flag[i] = 1'b1; f_id[i] = 6'o33; f_depth[i] = 24'(i); f_color[i] = 15'(32'h4000 + i);
        end
        run_frames(1, 1'b0, 1'b0, "R4 R5 same id");
    endtask

    // R5/R6: border against rear plane at clear depth 0x21FF
    task automatic test_border_depth();
        rear_id = 6'o02; clear_val = 15'h0010;
        for (int i = 0; i < TOTAL; i++) begin
            f_flag[i] = 1'b1; f_id[i] = 6'o41;
            f_depth[i] = (i % 2 == 0) ? 24'h21FE : 24'h21FF;
            f_color[i] = 15'(32'h5000 + i);
        end
        f_flag[10] = 1'b0;
        run_frames(1, 1'b0, 1'b0, "R6 border depth");
        check(exp_color(0) == pal_entry(4), "R6", "model border edge", 32'(exp_color(0)), 32'(pal_entry(4)));
        check(exp_color(1) == f_color[1], "R6", "model border equal", 32'(exp_color(1)), 32'(f_color[1]));
    endtask

    // R8/R9: stalls both sides, two frames back to back
    task automatic test_stalls();
        set_depth_rule_frame();
        run_frames(2, 1'b1, 1'b1, "R8 R9 stalls");
    endtask

    initial begin
        for (int k = 0; k < 8; k++) edge_palette[k*15 +: 15] = pal_entry(k);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_passthrough();
        test_front_pair();
        test_depth_rule();
        test_same_id();
        test_border_depth();
        test_stalls();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule